// File: doc/BRIEF.md
# Packed Halfword Multiply-Accumulate Unit

This block is a single-stage arithmetic unit for a DSP datapath. Each source operand carries one or two 32-bit elements, and each element is split into two signed 16-bit halves. The unit forms 16x16 signed products from chosen halves and folds them into a signed 64-bit accumulator. A 4-bit opcode picks one of eleven operations:

- a self product of the second source's halves, added to the first source;
- a single product: bottom-bottom, bottom-top or top-top;
- a sum of two products, in straight or crossed pairing;
- three difference-of-products forms;
- two forms that subtract both products from the accumulator.

A mode input picks a narrow datapath, which uses element 0 only, or a wide datapath, which adds in both elements. The result sits in one output register behind a valid/ready handshake. A new operation can enter in the same cycle that the previous result leaves.

Top module: `hmac64_unit`

## Requirements
- R1: Opcode 1 adds the sign-extended product src1.bottom × src2.bottom to `in_acc`. Opcode 2 adds src1.bottom × src2.top. Opcode 3 adds src1.top × src2.top. Within each 32-bit element, the bottom half is bits [15:0] and the top half is bits [31:16]. All halves are signed.
- R2: Opcode 0 adds the product src2.top × src2.bottom to the 64-bit value of `in_src1`. `in_acc` has no effect on the result.
- R3: Opcode 4 adds top×top and bottom×bottom, each sign-extended on its own, to `in_acc`. Opcode 5 adds src1.top×src2.bottom and src1.bottom×src2.top in the same way.
- R4: Opcode 6 forms top×top − bottom×bottom. Opcode 7 forms bottom×bottom − top×top. Opcode 8 forms src1.top×src2.bottom − src1.bottom×src2.top. In each case the difference is kept to 32 bits, then sign-extended and added to `in_acc`.
- R5: Opcode 9 subtracts both straight products (top×top and bottom×bottom) from `in_acc`. Opcode 10 subtracts both crossed products.
- R6: With `in_wide`=1, the per-element term is computed for element 0 (bits [31:0]) and for element 1 (bits [63:32]), and both are summed into the result. Element 1 takes every half from element 1 of both sources.
- R7: With `in_wide`=0, only element 0 contributes. Bits [63:32] of both sources have no effect on the result.
- R8: The 64-bit accumulation wraps modulo 2^64, with no saturation.
- R9: Opcodes 11 to 15 return `in_acc` unchanged with `out_illegal`=1. Opcodes 0 to 10 return `out_illegal`=0.
- R10: An operation is accepted when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or `out_ready` is high. The result shows on `out_valid` one cycle after acceptance. It is held stable while `out_ready` is low, and results leave in acceptance order.
- R11: After reset, `out_valid`, `out_illegal` and `out_result` are 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken this cycle |
| in_wide | input | 1 | 1: both elements, 0: element 0 only |
| in_op | input | 4 | Operation code, 0 to 10 legal |
| in_src1 | input | 64 | First packed source |
| in_src2 | input | 64 | Second packed source |
| in_acc | input | 64 | Signed accumulator input |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 64 | Signed 64-bit result |
| out_illegal | output | 1 | Result came from an unused opcode |

## Verification
Two events can coincide at one clock edge: the held result is taken by the consumer, and a new operation is captured into the same register. The bench provokes this by streaming operations back to back while `out_ready` is toggled at random, so stalls, releases and simultaneous release-and-capture all occur. A scoreboard records each operation's expected value at the moment it is accepted, and pops one entry per completed output transfer. A result that is lost, duplicated or overwritten during a stall therefore appears as a mismatch or as a queue that does not drain. A separate check confirms that a stalled result does not change between cycles.

// File: rtl/hmac_pkg.sv
package hmac_pkg;

    localparam int OP_W    = 4;
    localparam int NUM_OPS = 11;

    typedef enum logic [OP_W-1:0] {
        OP_SELF     = 4'd0,
        OP_MUL_BB   = 4'd1,
        OP_MUL_BT   = 4'd2,
        OP_MUL_TT   = 4'd3,
        OP_DUAL     = 4'd4,
        OP_DUALX    = 4'd5,
        OP_DIFF     = 4'd6,
        OP_DIFFR    = 4'd7,
        OP_DIFFX    = 4'd8,
        OP_SUBDUAL  = 4'd9,
        OP_SUBDUALX = 4'd10
    } hmac_op_e;

    // How one element's products become its 64-bit term
    typedef enum logic [1:0] {
        K_SINGLE = 2'd0,
        K_SUM    = 2'd1,
        K_DIFF   = 2'd2,
        K_NEG    = 2'd3
    } term_kind_e;

    typedef enum logic [1:0] {
        S_BB   = 2'd0,
        S_BT   = 2'd1,
        S_TT   = 2'd2,
        S_SELF = 2'd3
    } single_sel_e;

    typedef struct packed {
        logic        legal;
        logic        base_src1;
        term_kind_e  kind;
        single_sel_e single;
        logic        crossed;
        logic        reverse;
    } hmac_ctrl_t;

endpackage

// File: rtl/hmac_decode.sv
module hmac_decode
    import hmac_pkg::*;
(
    input  logic [OP_W-1:0] op,
    output hmac_ctrl_t      ctrl
);

    always_comb begin
        ctrl        = '0;
        ctrl.legal  = 1'b1;
        ctrl.kind   = K_SINGLE;
        ctrl.single = S_BB;
        case (op)
            OP_SELF: begin
                ctrl.single    = S_SELF;
                ctrl.base_src1 = 1'b1;
            end
            OP_MUL_BB:   ctrl.single = S_BB;
            OP_MUL_BT:   ctrl.single = S_BT;
            OP_MUL_TT:   ctrl.single = S_TT;
            OP_DUAL:     ctrl.kind   = K_SUM;
            OP_DUALX: begin
                ctrl.kind    = K_SUM;
                ctrl.crossed = 1'b1;
            end
            OP_DIFF:     ctrl.kind   = K_DIFF;
            OP_DIFFR: begin
                ctrl.kind    = K_DIFF;
                ctrl.reverse = 1'b1;
            end
            OP_DIFFX: begin
                ctrl.kind    = K_DIFF;
                ctrl.crossed = 1'b1;
            end
            OP_SUBDUAL:  ctrl.kind   = K_NEG;
            OP_SUBDUALX: begin
                ctrl.kind    = K_NEG;
                ctrl.crossed = 1'b1;
            end
            default:     ctrl.legal  = 1'b0;
        endcase
    end

endmodule

// File: rtl/hmac_lane.sv
module hmac_lane
    import hmac_pkg::*;
#(
    parameter int HALF_W = 16,
    parameter int ACC_W  = 64
) (
    input  logic [2*HALF_W-1:0] a_elem,
    input  logic [2*HALF_W-1:0] b_elem,
    input  term_kind_e          kind,
    input  single_sel_e         single,
    input  logic                crossed,
    input  logic                reverse,
    output logic [ACC_W-1:0]    term
);

    localparam int PROD_W = 2 * HALF_W;
    localparam int EXT_W  = ACC_W - PROD_W;

    logic signed [HALF_W-1:0] a_lo, a_hi, b_lo, b_hi;
    logic signed [PROD_W-1:0] p_bb, p_tt, p_bt, p_tb, p_self;
    logic signed [PROD_W-1:0] p_first, p_second, p_one, p_diff;
    logic        [ACC_W-1:0]  pair_sum;

    function automatic logic [ACC_W-1:0] sext(input logic [PROD_W-1:0] v);
        return {{EXT_W{v[PROD_W-1]}}, v};
    endfunction

    assign a_lo = a_elem[HALF_W-1:0];
    assign a_hi = a_elem[PROD_W-1:HALF_W];
    assign b_lo = b_elem[HALF_W-1:0];
    assign b_hi = b_elem[PROD_W-1:HALF_W];

    assign p_bb   = PROD_W'(a_lo) * PROD_W'(b_lo);
    assign p_tt   = PROD_W'(a_hi) * PROD_W'(b_hi);
    assign p_bt   = PROD_W'(a_lo) * PROD_W'(b_hi);
    assign p_tb   = PROD_W'(a_hi) * PROD_W'(b_lo);
    assign p_self = PROD_W'(b_hi) * PROD_W'(b_lo);

    always_comb begin
        p_first  = crossed ? p_tb : p_tt;
        p_second = crossed ? p_bt : p_bb;
        case (single)
            S_BB:    p_one = p_bb;
            S_BT:    p_one = p_bt;
            S_TT:    p_one = p_tt;
            default: p_one = p_self;
        endcase
        // difference kept at product width, so it wraps before widening
        p_diff   = reverse ? (p_second - p_first) : (p_first - p_second);
        pair_sum = sext(p_first) + sext(p_second);
        case (kind)
            K_SINGLE: term = sext(p_one);
            K_SUM:    term = pair_sum;
            K_DIFF:   term = sext(p_diff);
            default:  term = '0 - pair_sum;
        endcase
    end

endmodule

// File: rtl/hmac_sum.sv
module hmac_sum #(
    parameter int ACC_W = 64,
    parameter int ELEMS = 2
) (
    input  logic [ELEMS*ACC_W-1:0] terms,
    input  logic [ELEMS-1:0]       lane_en,
    input  logic [ACC_W-1:0]       base,
    output logic [ACC_W-1:0]       total
);

    always_comb begin
        total = base;
        for (int e = 0; e < ELEMS; e++) begin
            if (lane_en[e]) begin
                total = total + terms[e*ACC_W +: ACC_W];
            end
        end
    end

endmodule

// File: rtl/hmac64_unit.sv
module hmac64_unit
    import hmac_pkg::*;
#(
    parameter int HALF_W = 16,
    parameter int ACC_W  = 64,
    parameter int ELEMS  = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    output logic                      in_ready,
    input  logic                      in_wide,
    input  logic [OP_W-1:0]           in_op,
    input  logic [ELEMS*2*HALF_W-1:0] in_src1,
    input  logic [ELEMS*2*HALF_W-1:0] in_src2,
    input  logic [ACC_W-1:0]          in_acc,
    output logic                      out_valid,
    input  logic                      out_ready,
    output logic [ACC_W-1:0]          out_result,
    output logic                      out_illegal
);

    localparam int ELEM_W = 2 * HALF_W;

    typedef struct packed {
        logic             valid;
        logic             illegal;
        logic [ACC_W-1:0] result;
    } state_t;

    state_t                   st_d, st_q;
    hmac_ctrl_t               ctrl;
    logic [ELEMS*ACC_W-1:0]   lane_terms;
    logic [ELEMS-1:0]         lane_en;
    logic [ACC_W-1:0]         base_val;
    logic [ACC_W-1:0]         total;
    logic                     accept;

    hmac_decode u_dec (
        .op   (in_op),
        .ctrl (ctrl)
    );

    generate
        for (genvar e = 0; e < ELEMS; e++) begin : g_lane
            assign lane_en[e] = (e == 0) || in_wide;
            hmac_lane #(
                .HALF_W (HALF_W),
                .ACC_W  (ACC_W)
            ) u_lane (
                .a_elem  (in_src1[e*ELEM_W +: ELEM_W]),
                .b_elem  (in_src2[e*ELEM_W +: ELEM_W]),
                .kind    (ctrl.kind),
                .single  (ctrl.single),
                .crossed (ctrl.crossed),
                .reverse (ctrl.reverse),
                .term    (lane_terms[e*ACC_W +: ACC_W])
            );
        end
    endgenerate

    assign base_val = ctrl.base_src1 ? ACC_W'(in_src1) : in_acc;

    hmac_sum #(
        .ACC_W (ACC_W),
        .ELEMS (ELEMS)
    ) u_sum (
        .terms   (lane_terms),
        .lane_en (lane_en),
        .base    (base_val),
        .total   (total)
    );

    assign in_ready = !st_q.valid || out_ready;
    assign accept   = in_valid && in_ready;

    always_comb begin
        st_d = st_q;
        if (accept) begin
            st_d.valid   = 1'b1;
            st_d.illegal = !ctrl.legal;
            st_d.result  = ctrl.legal ? total : in_acc;
        end else if (out_ready) begin
            st_d.valid   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid   = st_q.valid;
    assign out_illegal = st_q.illegal;
    assign out_result  = st_q.result;

endmodule

// File: rtl/hmac64_unit_chk.sv
module hmac64_unit_chk
    import hmac_pkg::*;
#(
    parameter int HALF_W = 16,
    parameter int ACC_W  = 64,
    parameter int ELEMS  = 2
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      in_valid,
    input logic                      in_ready,
    input logic                      in_wide,
    input logic [OP_W-1:0]           in_op,
    input logic [ELEMS*2*HALF_W-1:0] in_src1,
    input logic [ELEMS*2*HALF_W-1:0] in_src2,
    input logic [ACC_W-1:0]          in_acc,
    input logic                      out_valid,
    input logic                      out_ready,
    input logic [ACC_W-1:0]          out_result,
    input logic                      out_illegal
);

    localparam int PW = 2 * HALF_W;

    logic signed [HALF_W-1:0] c_a_lo, c_b_lo, c_b_hi;
    logic signed [PW-1:0]     c_bb, c_self;
    logic [ACC_W-1:0]         c_bb_exp, c_self_exp;
    logic                     c_take;

    assign c_a_lo     = in_src1[HALF_W-1:0];
    assign c_b_lo     = in_src2[HALF_W-1:0];
    assign c_b_hi     = in_src2[PW-1:HALF_W];
    assign c_bb       = PW'(c_a_lo) * PW'(c_b_lo);
    assign c_self     = PW'(c_b_hi) * PW'(c_b_lo);
    assign c_bb_exp   = in_acc + {{(ACC_W-PW){c_bb[PW-1]}}, c_bb};
    assign c_self_exp = ACC_W'(in_src1) + {{(ACC_W-PW){c_self[PW-1]}}, c_self};
    assign c_take     = in_valid && in_ready;

    AST_TAKE_THEN_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        c_take |=> out_valid);                                                    // R10

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_illegal)); // R10

    AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !in_ready);                                   // R10

    AST_UNUSED_OP_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        c_take && (in_op >= OP_W'(NUM_OPS)) |=> out_illegal && (out_result == $past(in_acc))); // R9

    AST_USED_OP_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        c_take && (in_op < OP_W'(NUM_OPS)) |=> !out_illegal);                     // R9

    AST_NARROW_BB: assert property (@(posedge clk) disable iff (!rst_n)
        c_take && !in_wide && (in_op == OP_W'(1)) |=> out_result == $past(c_bb_exp)); // R1

    AST_NARROW_SELF: assert property (@(posedge clk) disable iff (!rst_n)
        c_take && !in_wide && (in_op == OP_W'(0)) |=> out_result == $past(c_self_exp)); // R2

endmodule

bind hmac64_unit hmac64_unit_chk #(
    .HALF_W (HALF_W),
    .ACC_W  (ACC_W),
    .ELEMS  (ELEMS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_wide     (in_wide),
    .in_op       (in_op),
    .in_src1     (in_src1),
    .in_src2     (in_src2),
    .in_acc      (in_acc),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_result  (out_result),
    .out_illegal (out_illegal)
);

// File: tb/sim_hmac64_unit.sv
`timescale 1ns/1ps
module sim_hmac64_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic        in_wide = 1'b0;
    logic [3:0]  in_op = '0;
    logic [63:0] in_src1 = '0;
    logic [63:0] in_src2 = '0;
    logic [63:0] in_acc = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [63:0] out_result;
    logic        out_illegal;

    int n_checks = 0;
    int n_fail   = 0;
    bit mon_on   = 1'b0;
    bit ready_rand = 1'b0;
    bit done     = 1'b0;

    logic [63:0] q_res[$];
    logic        q_ill[$];
    string       q_tag[$];

    always #2.5 clk = ~clk;

    hmac64_unit u0 (
        .clk (clk), .rst_n (rst_n),
        .in_valid (in_valid), .in_ready (in_ready), .in_wide (in_wide),
        .in_op (in_op), .in_src1 (in_src1), .in_src2 (in_src2), .in_acc (in_acc),
        .out_valid (out_valid), .out_ready (out_ready),
        .out_result (out_result), .out_illegal (out_illegal)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // reference computed from the requirement text
    function automatic logic [63:0] model(input logic [3:0] op, input logic wide,
                                          input logic [63:0] s1, input logic [63:0] s2,
                                          input logic [63:0] acc);
        longint sum;
        if (op > 4'd10) return acc;
        sum = (op == 4'd0) ? longint'(s1) : longint'(acc);
        for (int e = 0; e < (wide ? 2 : 1); e++) begin
            longint ab, at, bb, bt;
            longint m_bb, m_tt, m_bt, m_tb;
            ab = longint'(shortint'(s1[32*e +: 16]));
            at = longint'(shortint'(s1[32*e+16 +: 16]));
            bb = longint'(shortint'(s2[32*e +: 16]));
            bt = longint'(shortint'(s2[32*e+16 +: 16]));
            m_bb = ab * bb; m_tt = at * bt; m_bt = ab * bt; m_tb = at * bb;
            case (op)
                4'd0:  sum += bt * bb;
                4'd1:  sum += m_bb;
                4'd2:  sum += m_bt;
                4'd3:  sum += m_tt;
                4'd4:  sum += m_tt + m_bb;
                4'd5:  sum += m_tb + m_bt;
                4'd6:  sum += longint'(int'(m_tt - m_bb));
                4'd7:  sum += longint'(int'(m_bb - m_tt));
                4'd8:  sum += longint'(int'(m_tb - m_bt));
                4'd9:  sum -= m_tt + m_bb;
                default: sum -= m_tb + m_bt;
            endcase
        end
        return 64'(sum);
    endfunction

    task automatic send(input logic [3:0] op, input logic wide, input logic [63:0] s1,
                        input logic [63:0] s2, input logic [63:0] acc, input string tag);
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_wide = wide;
        in_src1 = s1; in_src2 = s2; in_acc = acc;
        #2;
        while (!in_ready) begin
            @(negedge clk);
            #2;
        end
        q_res.push_back(model(op, wide, s1, s2, acc));
        q_ill.push_back(op > 4'd10);
        q_tag.push_back(tag);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // monitor: drives out_ready and scores every completed transfer
    initial begin
        bit          prev_stall;
        logic [63:0] prev_res;
        prev_stall = 1'b0;
        prev_res   = '0;
        forever begin
            @(negedge clk);
            if (mon_on) begin
                out_ready = ready_rand ? (($urandom % 3) != 0) : 1'b1;
                #1;
                check("R10 in_ready rule", 64'(in_ready), 64'(!out_valid || out_ready));
                if (prev_stall) begin
                    check("R10 stall keeps valid", 64'(out_valid), 64'd1);
                    check("R10 stall keeps result", out_result, prev_res);
                end
                if (out_valid && out_ready) begin
                    if (q_res.size() == 0) begin
                        n_checks++; n_fail++;
                        $display("FAIL R10: actual unexpected result %h expected none", out_result);
                    end else begin
                        string t;
                        logic [63:0] r;
                        logic il;
                        t = q_tag.pop_front(); r = q_res.pop_front(); il = q_ill.pop_front();
                        check(t, out_result, r);
                        check({t, " flag R9"}, 64'(out_illegal), 64'(il));
                    end
                end
                prev_stall = out_valid && !out_ready;
                prev_res   = out_result;
            end
        end
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        #1;
        check("R11 out_valid", 64'(out_valid), 64'd0);
        check("R11 out_illegal", 64'(out_illegal), 64'd0);
        check("R11 out_result", out_result, 64'd0);
        check("R11 in_ready", 64'(in_ready), 64'd1);
        mon_on = 1'b1;

        // R1 single products, negative halves
        send(4'd1, 1'b0, 64'h0000_0000_0003_FFFB, 64'h0000_0000_0007_FFF9, 64'd100, "R1 bb");
        send(4'd2, 1'b0, 64'h0000_0000_0003_FFFB, 64'h0000_0000_0007_FFF9, 64'd100, "R1 bt");
        send(4'd3, 1'b0, 64'h0000_0000_0003_FFFB, 64'h0000_0000_0007_FFF9, 64'd100, "R1 tt");
        send(4'd1, 1'b0, 64'h0000_0000_0000_8000, 64'h0000_0000_0000_8000, 64'd0,   "R1 min*min");
        // R7 narrow: upper garbage must not matter
        send(4'd4, 1'b0, 64'hDEAD_BEEF_0003_FFFB, 64'h8000_7FFF_0007_FFF9, 64'd5, "R7 narrow dual");
        send(4'd1, 1'b0, 64'h1234_5678_0003_FFFB, 64'hFFFF_FFFF_0007_FFF9, 64'd100, "R7 narrow bb");
        // R2 self product, accumulator ignored
        send(4'd0, 1'b0, 64'h1234_5678_0000_1000, 64'h0000_0000_8000_7FFF, 64'hFFFF_FFFF_FFFF_FFFF, "R2 narrow");
        send(4'd0, 1'b1, 64'h0000_0000_0000_0010, 64'hFFFE_0003_8000_8000, 64'h0123_4567_89AB_CDEF, "R2 wide");
        // R3 dual sums
        send(4'd4, 1'b0, 64'h0, 64'h0000_0000_8000_8000 ^ 64'h0, 64'd7, "R3 dual zero src1");
        send(4'd4, 1'b0, 64'h0000_0000_8000_8000, 64'h0000_0000_8000_8000, 64'd0, "R3 dual max");
        send(4'd5, 1'b0, 64'h0000_0000_0002_FFFD, 64'h0000_0000_0005_0007, -64'sd9, "R3 crossed");
        // R4 differences, including extreme halves
        send(4'd6, 1'b0, 64'h0000_0000_8000_8000, 64'h0000_0000_8000_7FFF, 64'd0, "R4 diff");
        send(4'd7, 1'b0, 64'h0000_0000_8000_8000, 64'h0000_0000_8000_7FFF, 64'd0, "R4 rdiff");
        send(4'd8, 1'b0, 64'h0000_0000_8000_7FFF, 64'h0000_0000_7FFF_8000, 64'd1, "R4 xdiff");
        send(4'd6, 1'b0, 64'h0000_0000_7FFF_8000, 64'h0000_0000_8000_7FFF, 64'h8000_0000_0000_0000, "R4 diff neg");
        // R5 subtract from accumulator
        send(4'd9,  1'b0, 64'h0000_0000_0003_0004, 64'h0000_0000_0005_0006, 64'd1000, "R5 sub");
        send(4'd10, 1'b0, 64'h0000_0000_0003_0004, 64'h0000_0000_0005_0006, 64'd1000, "R5 subx");
        // R6 wide, element 1 distinct from element 0
        for (int op = 0; op <= 10; op++) begin
            send(4'(op), 1'b1, 64'h8000_0011_FFFD_0004, 64'h7FFF_FFF0_0005_8000, 64'd12345, "R6 wide");
        end
        // R8 wrap-around
        send(4'd3, 1'b0, 64'h0000_0000_0002_0000, 64'h0000_0000_0003_0000, 64'h7FFF_FFFF_FFFF_FFFF, "R8 wrap up");
        send(4'd9, 1'b1, 64'h0001_0001_0001_0001, 64'h0001_0001_0001_0001, 64'h8000_0000_0000_0000, "R8 wrap down");
        // R9 unused codes
        for (int op = 11; op <= 15; op++) begin
            send(4'(op), 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1111_2222_3333_4444, 64'hA5A5_0000_5A5A_FFFF, "R9 unused");
        end
        idle();

        // R10 random traffic under back-pressure
        ready_rand = 1'b1;
        for (int i = 0; i < 400; i++) begin
            logic [63:0] a, b, c;
            a = {$urandom, $urandom};
            b = {$urandom, $urandom};
            c = {$urandom, $urandom};
            if ((i % 7) == 0) a[15:0] = 16'h8000;
            if ((i % 5) == 0) b[31:16] = 16'h8000;
            send(4'($urandom % 16), 1'($urandom % 2), a, b, c, "R10 stream");
            if ((i % 11) == 0) idle();
        end
        idle();
        ready_rand = 1'b0;
        for (int w = 0; w < 50 && q_res.size() != 0; w++) @(negedge clk);
        repeat (2) @(negedge clk);
        check("R10 all results delivered", 64'(q_res.size()), 64'd0);
        done = 1'b1;
        finish_run();
    end

endmodule